// File: doc/BRIEF.md
# Variable-Length Serial Peripheral Master

This block is a single-channel serial peripheral interface master whose datapath is one 16-bit shift register. The host configures a character length between 1 and 16 bits, a clock half-period and an interrupt enable. Writing a transmit word starts a transfer. The block then pulls chip select low, produces a clock that idles low, and shifts the word out of its top bit. At the same time it shifts the sampled input line into the bottom bit.

Short characters are placed at the top of the written word. They come back at the bottom of the receive buffer, and the upper bits of that buffer are don't-care. When the last bit has been sampled and the trailing gap has passed, chip select rises, the receive buffer takes the register contents and a completion flag is set. A host read strobe clears the flag. A software hold input keeps the block idle, and a talk input gates whether a write may start a transfer.

Top module: `spi_char_master`

## Requirements
- R1: With `cfg_talk`=1, `cfg_soft_reset`=0 and the block idle, a `tx_wr` pulse makes `spi_cs_n` low and `busy` high in the next cycle.
- R2: The number of bits shifted out is L = `cfg_char_len`+1, where `cfg_char_len`=0 gives 1 bit and 15 gives 16 bits. The bits are `tx_data[15]`, `tx_data[14]` and so on down to `tx_data[16-L]`, each driven on `spi_mosi` after a rising `spi_sclk`.
- R3: After a transfer, `rx_data[L-1:0]` holds the sampled input bits with the first sampled bit at position L-1. Each bit is sampled on a falling `spi_sclk`.
- R4: `spi_sclk` is low whenever `spi_cs_n` is high. Each high phase and each low phase lasts H clock cycles, where H = `cfg_half_per`, and values below 2 are treated as 2. `spi_mosi` does not change while `spi_sclk` is high.
- R5: Chip select falls H cycles before the first rising clock and rises H cycles after the last falling clock, so `busy` stays high for exactly H*(2L+1) cycles.
- R6: When chip select rises at the end of a transfer, `rx_data` is updated and `int_flag` becomes 1 in the same cycle.
- R7: `irq` is high only while both `int_flag` and `cfg_int_en` are 1.
- R8: An `rx_rd` pulse clears `int_flag` in the next cycle, unless a transfer completes in that same cycle.
- R9: A `tx_wr` while `busy` is high is ignored, and the running transfer keeps its data, length and duration.
- R10: A `tx_wr` while `cfg_talk`=0 starts nothing: `busy` stays low and `spi_cs_n` stays high.
- R11: While `cfg_soft_reset`=1 the block is held idle: `spi_cs_n`=1, `spi_sclk`=0, `busy`=0, `int_flag`=0, `rx_data`=0, and writes are ignored. This also aborts a running transfer.
- R12: The synchronous `rst` puts the block into the same idle state as R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_soft_reset | input | 1 | 1 holds the block in reset |
| cfg_talk | input | 1 | 1 allows writes to start transfers |
| cfg_int_en | input | 1 | Enables the `irq` output |
| cfg_char_len | input | 4 | Character length minus one |
| cfg_half_per | input | 8 | Serial clock half-period in clock cycles (minimum 2) |
| tx_wr | input | 1 | Transmit write strobe |
| tx_data | input | 16 | Transmit word, left-justified |
| rx_rd | input | 1 | Receive read strobe; clears the flag |
| rx_data | output | 16 | Receive buffer, right-justified |
| busy | output | 1 | Transfer in progress |
| int_flag | output | 1 | Character-complete flag |
| irq | output | 1 | Interrupt request |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
A wrong bit counter or a wrong latched length shows up at once as too many or too few falling clock edges. The same fault makes `busy` last a different time than H*(2L+1), and `rx_data` ends up misaligned when the flag rises. A wrong phase counter changes the widths of the clock phases and the setup and hold gaps around chip select, which the transfer duration shows within one character. A shift register that loads the wrong end or samples on the wrong edge corrupts both the bit stream captured by the modelled slave and the right-justified receive value. A flag that fails to clear or fails to gate is visible on `int_flag` and `irq` one cycle after the read strobe or the enable change.

// File: rtl/spi_char_pkg.sv
package spi_char_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_HIGH,
    PH_LOW,
    PH_TRAIL
  } spi_phase_e;
endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [HALF_W-1:0] half_per,
  output logic              tick
);
  localparam logic [HALF_W-1:0] MIN_HALF = HALF_W'(2);

  logic [HALF_W-1:0] cnt;
  logic [HALF_W-1:0] eff;

  assign eff  = (half_per < MIN_HALF) ? MIN_HALF : half_per;
  assign tick = run && (cnt >= eff - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  // R4
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         shift,
  input  logic         ser_in,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= load_data;
    else if (shift) q <= {q[W-2:0], ser_in};
  end

  // R3
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    shift && !load |=> q[0] == $past(ser_in));
endmodule

// File: rtl/spi_char_master.sv
module spi_char_master #(
  parameter int DATA_W = 16,
  parameter int HALF_W = 8,
  localparam int LEN_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_soft_reset,
  input  logic              cfg_talk,
  input  logic              cfg_int_en,
  input  logic [LEN_W-1:0]  cfg_char_len,
  input  logic [HALF_W-1:0] cfg_half_per,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              busy,
  output logic              int_flag,
  output logic              irq,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  import spi_char_pkg::*;

  spi_phase_e        phase;
  logic              hold;
  logic              start;
  logic              tick;
  logic              done;
  logic              shift_en;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] sh_q;

  assign hold     = rst || cfg_soft_reset;
  assign start    = tx_wr && cfg_talk && (phase == PH_IDLE);
  assign done     = (phase == PH_TRAIL) && tick;
  assign shift_en = (phase == PH_HIGH) && tick;
  assign busy     = (phase != PH_IDLE);
  assign irq      = int_flag && cfg_int_en;

  spi_half_timer #(.HALF_W(HALF_W)) u_timer (
    .clk      (clk),
    .rst      (hold),
    .run      (busy),
    .half_per (cfg_half_per),
    .tick     (tick)
  );

  spi_shifter #(.W(DATA_W)) u_shifter (
    .clk       (clk),
    .rst       (hold),
    .load      (start),
    .load_data (tx_data),
    .shift     (shift_en),
    .ser_in    (spi_miso),
    .q         (sh_q)
  );

  always_ff @(posedge clk) begin
    if (hold) begin
      phase    <= PH_IDLE;
      spi_cs_n <= 1'b1;
      spi_sclk <= 1'b0;
      spi_mosi <= 1'b0;
      bit_cnt  <= '0;
      len_q    <= '0;
      rx_data  <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase    <= PH_LEAD;
          spi_cs_n <= 1'b0;
          bit_cnt  <= '0;
          len_q    <= cfg_char_len;
        end
        PH_LEAD, PH_LOW: if (tick) begin
          spi_sclk <= 1'b1;
          spi_mosi <= sh_q[DATA_W-1];
          phase    <= PH_HIGH;
        end
        PH_HIGH: if (tick) begin
          spi_sclk <= 1'b0;
          if (bit_cnt == len_q) begin
            phase <= PH_TRAIL;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
            phase   <= PH_LOW;
          end
        end
        PH_TRAIL: if (tick) begin
          spi_cs_n <= 1'b1;
          spi_mosi <= 1'b0;
          rx_data  <= sh_q;
          phase    <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (hold)       int_flag <= 1'b0;
    else if (done)  int_flag <= 1'b1;
    else if (rx_rd) int_flag <= 1'b0;
  end

  // R4
  idle_clk_chk: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk);

  // R4
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    spi_sclk && $past(spi_sclk) |-> $stable(spi_mosi));

  // R5
  cs_lead_chk: assert property (@(posedge clk) disable iff (hold)
    $fell(spi_cs_n) |=> !spi_sclk);

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rx_rd && !done |=> !int_flag);

  // R11
  soft_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_soft_reset |=> spi_cs_n && !busy && !int_flag);

  // R7
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> int_flag);

  // R9
  busy_write_chk: assert property (@(posedge clk) disable iff (hold)
    busy && tx_wr && !done |=> busy);
endmodule

// File: tb/spi_char_master_bench.sv
module spi_char_master_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_soft_reset = 1'b0;
  logic        cfg_talk = 1'b1;
  logic        cfg_int_en = 1'b0;
  logic [3:0]  cfg_char_len = 4'hF;
  logic [7:0]  cfg_half_per = 8'd2;
  logic        tx_wr = 1'b0;
  logic [15:0] tx_data = '0;
  logic        rx_rd = 1'b0;
  logic [15:0] rx_data;
  logic        busy, int_flag, irq, spi_cs_n, spi_sclk, spi_mosi;
  logic        spi_miso;

  logic [15:0] tb_slv = '0;
  logic [15:0] cap = '0;
  int          nbits = 0;
  int          nchk = 0;
  int          nerr = 0;
  int          busy_cyc;
  int          cycles = 0;
  bit          done_flag = 0;

  always #5 clk = ~clk;

  spi_char_master u_spi_char_master (
    .clk(clk), .rst(rst), .cfg_soft_reset(cfg_soft_reset), .cfg_talk(cfg_talk),
    .cfg_int_en(cfg_int_en), .cfg_char_len(cfg_char_len), .cfg_half_per(cfg_half_per),
    .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd), .rx_data(rx_data),
    .busy(busy), .int_flag(int_flag), .irq(irq), .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // modelled slave: presents its top bit, shifts after each falling clock
  assign spi_miso = tb_slv[15];
  always @(negedge spi_sclk) begin
    if (!spi_cs_n) begin
      cap    <= {cap[14:0], spi_mosi};
      tb_slv <= {tb_slv[14:0], 1'b0};
      nbits  <= nbits + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] top_bits(input logic [15:0] w, input int len);
    logic [16:0] m;
    m = (17'd1 << len) - 17'd1;
    return (w >> (16 - len)) & m[15:0];
  endfunction

  // dup_at >= 0 issues a second write that many cycles into the transfer
  task automatic do_xfer(input logic [3:0] lm1, input logic [7:0] hp,
                         input logic [15:0] tx, input logic [15:0] sv, input int dup_at);
    int len, h, guard;
    len = int'(lm1) + 1;
    h   = (hp < 2) ? 2 : int'(hp);
    cfg_char_len = lm1; cfg_half_per = hp;
    tb_slv = sv; cap = '0; nbits = 0;
    @(negedge clk); tx_data = tx; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
    chk("R1 cs/busy", {30'd0, spi_cs_n, busy}, 32'b01);
    busy_cyc = 0; guard = 0;
    while (!int_flag && guard < 5000) begin
      if (busy) busy_cyc++;
      tx_wr = (guard == dup_at);
      tx_data = (guard == dup_at) ? ~tx : tx;
      @(negedge clk);
      guard++;
    end
    tx_wr = 1'b0;
    chk("R6 flag", {31'd0, int_flag}, 32'd1);
    chk("R6 cs high", {31'd0, spi_cs_n}, 32'd1);
    chk("R3 rx", {16'd0, top_bits(rx_data << (16 - len), len)}, {16'd0, top_bits(sv, len)});
    chk("R2 mosi", {16'd0, cap}, {16'd0, top_bits(tx, len)});
    chk("R2 nbits", nbits, len);
    chk("R5 R4 duration", busy_cyc, h * (2 * len + 1));
  endtask

  task automatic pulse_rd();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  localparam logic [43:0] VEC [6] = '{
    {4'hF, 8'd2, 16'hA5C3, 16'h3C96},
    {4'h7, 8'd3, 16'hB400, 16'h81FF},
    {4'h0, 8'd2, 16'h8000, 16'h8000},
    {4'hB, 8'd4, 16'h5550, 16'hCAFE},
    {4'h3, 8'd5, 16'h9000, 16'h6000},
    {4'h0, 8'd0, 16'h0000, 16'hFFFF}
  };

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    chk("R12 reset", {12'd0, spi_cs_n, spi_sclk, busy, int_flag, irq, rx_data},
        {12'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000});

    // table walk: R2 R3 R4 R5 R6
    foreach (VEC[i]) begin
      do_xfer(VEC[i][43:40], VEC[i][39:32], VEC[i][31:16], VEC[i][15:0], -1);
      pulse_rd();
    end

    // R7 irq gating, R8 read clear
    cfg_int_en = 1'b0;
    do_xfer(4'h7, 8'd2, 16'hC300, 16'h5A00, -1);
    chk("R7 irq masked", {31'd0, irq}, 32'd0);
    cfg_int_en = 1'b1; #1;
    chk("R7 irq enabled", {31'd0, irq}, 32'd1);
    pulse_rd();
    chk("R8 flag cleared", {31'd0, int_flag}, 32'd0);
    chk("R7 irq dropped", {31'd0, irq}, 32'd0);

    // R9 write while busy ignored
    do_xfer(4'h9, 8'd3, 16'h6A40, 16'h9C00, 7);
    pulse_rd();

    // R10 talk disabled
    cfg_talk = 1'b0;
    @(negedge clk); tx_data = 16'hFFFF; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
    repeat (10) @(negedge clk);
    chk("R10 no start", {30'd0, spi_cs_n, busy}, 32'b10);
    cfg_talk = 1'b1;

    // R11 soft reset clears flag and buffer, blocks writes, aborts transfer
    do_xfer(4'hF, 8'd2, 16'h1234, 16'hBEEF, -1);
    cfg_soft_reset = 1'b1;
    @(negedge clk);
    chk("R11 cleared", {13'd0, spi_cs_n, busy, int_flag, rx_data},
        {13'd0, 1'b1, 1'b0, 1'b0, 16'h0000});
    tx_wr = 1'b1; @(negedge clk); tx_wr = 1'b0;
    repeat (5) @(negedge clk);
    chk("R11 write blocked", {30'd0, spi_cs_n, busy}, 32'b10);
    cfg_soft_reset = 1'b0;
    @(negedge clk); tx_data = 16'hF0F0; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
    repeat (6) @(negedge clk);
    cfg_soft_reset = 1'b1;
    @(negedge clk);
    chk("R11 abort", {29'd0, spi_cs_n, spi_sclk, busy}, 32'b100);
    cfg_soft_reset = 1'b0;

    // R12 synchronous reset mid-transfer
    @(negedge clk); tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R12 mid reset", {29'd0, spi_cs_n, spi_sclk, busy}, 32'b100);

    // R1 normal operation resumes after reset
    do_xfer(4'h4, 8'd2, 16'hA800, 16'h7000, -1);
    finish_run();
  end
endmodule